// File: doc/BRIEF.md
# Codec Mode Control and Suspend Sequencer

This block holds the 16-bit mode word of a video compression engine. It decides when the engine's datapath may run. A host writes the mode word. The block drives the encode/decode direction, the colour-component format, the quality-box and stall enables, and two polarity-adjusted pins: the horizontal sync and the host interrupt.

A software-reset bit in the mode word controls the processing-run enable.

- The bit comes out of hardware reset set, so the engine stays idle until the host clears it.
- If the bit is set again while the engine is decoding, the engine stops at once.
- If the bit is set while encoding, the engine stops at once when the timing logic reports vertical blank, because no field is in progress then.
- Otherwise the encoder keeps running until the field-end strobe and stops after it.
- Mode bits may only change while the software-reset bit is held. A write that breaks this rule is dropped and raises a sticky error flag.

Top module: `codec_mode_ctrl`

## Requirements
- R1: After a synchronous reset the mode word reads 0x0880: encode selected and software reset set. All other fields read 0, `run_en` is 0, `proto_err` is 0, `irq_o` is 1 and `hsync_o` is 0.
- R2: The mode word's bit positions are: bit 7 direction (1 encode, 0 decode), bit 9 colour format (1 unipolar, 0 bipolar), bit 11 software reset, bit 12 sync polarity, bit 13 interrupt polarity, bit 14 quality-box enable, bit 15 stall enable. An accepted write shows on `rd_data` and on the field outputs after the clock edge that samples it.
- R3: Bits 0 to 6, 8 and 10 always read 0, whatever value is written to them.
- R4: While the software-reset bit is set, `run_en` stays 0. After the edge that clears the bit, `run_en` rises at the next edge.
- R5: When the software-reset bit is set while running in decode, `run_en` falls at the edge after the one that sets the bit.
- R6: When the software-reset bit is set while running in encode with `vblank` low, `run_en` stays 1 until an edge samples `field_end` high. It falls at that edge.
- R7: When the software-reset bit is set while running in encode with `vblank` high, `run_en` falls at the next edge, as in decode.
- R8: If the software-reset bit is cleared while an encode suspend is still waiting for `field_end`, the engine keeps running and `run_en` never drops.
- R9: A write made while the software-reset bit is clear that would change any other mode bit is dropped whole. `proto_err` then rises at that edge and stays 1 until reset.
- R10: One edge after sampling, `hsync_o` equals `hblank` when bit 12 is 0, and equals `hblank` inverted when bit 12 is 1.
- R11: One edge after sampling, `irq_o` is low for a pending request when bit 13 is 0 (active low), and high for a pending request when bit 13 is 1 (active high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mode word write strobe |
| wr_data | input | 16 | Mode word write value |
| field_end | input | 1 | End-of-field strobe from video timing |
| vblank | input | 1 | Vertical blanking state from video timing |
| hblank | input | 1 | Horizontal blanking state, 1 during blanking |
| irq_req | input | 1 | Internal interrupt request, 1 when pending |
| rd_data | output | 16 | Current mode word |
| enc_mode | output | 1 | 1 encode, 0 decode |
| unipolar | output | 1 | 1 unipolar, 0 bipolar colour components |
| qbox_en | output | 1 | Quality-box enable |
| stall_en | output | 1 | Video stall enable |
| run_en | output | 1 | Processing-run enable for the datapath |
| proto_err | output | 1 | Sticky flag for a dropped mode write |
| hsync_o | output | 1 | Polarity-adjusted horizontal sync |
| irq_o | output | 1 | Polarity-adjusted interrupt pin |

## Verification
Every result has a fixed latency. Mode fields and `proto_err` change at the edge that samples the write. The pins change at the edge that samples `hblank` and `irq_req`. `run_en` starts one edge after the software-reset bit clears. It stops one edge after the bit is set in decode or in vertical blank, and at the edge that samples `field_end` in an encode drain. The reference model advances on the same rising edges from the same inputs. Inputs change only on falling edges, and every output is compared with the model on each falling edge, so each result is checked in the cycle it is due.

// File: rtl/codec_mode_pkg.sv
package codec_mode_pkg;
  localparam int MODE_W    = 16;
  localparam int BIT_DIR   = 7;
  localparam int BIT_UNI   = 9;
  localparam int BIT_SWR   = 11;
  localparam int BIT_HPOL  = 12;
  localparam int BIT_IPOL  = 13;
  localparam int BIT_QBOX  = 14;
  localparam int BIT_STALL = 15;

  localparam logic [MODE_W-1:0] SWR_ONLY  = MODE_W'(1) << BIT_SWR;
  localparam logic [MODE_W-1:0] MODE_MASK =
    (MODE_W'(1) << BIT_DIR)  | (MODE_W'(1) << BIT_UNI)  | SWR_ONLY |
    (MODE_W'(1) << BIT_HPOL) | (MODE_W'(1) << BIT_IPOL) |
    (MODE_W'(1) << BIT_QBOX) | (MODE_W'(1) << BIT_STALL);
  localparam logic [MODE_W-1:0] MODE_RST  = (MODE_W'(1) << BIT_DIR) | SWR_ONLY;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_t;
endpackage

// File: rtl/codec_mode_reg.sv
module codec_mode_reg
  import codec_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output logic [MODE_W-1:0] mode_q,
  output logic              err_q
);
  logic [MODE_W-1:0] wr_clean;
  logic              others_change;
  logic              reject;
  logic              accept;

  always_comb begin
    wr_clean      = wr_data & MODE_MASK;
    others_change = |((wr_clean ^ mode_q) & ~SWR_ONLY);
    reject        = wr_en & ~mode_q[BIT_SWR] & others_change;
    accept        = wr_en & ~reject;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RST;
      err_q  <= 1'b0;
    end else begin
      if (accept) mode_q <= wr_clean;
      if (reject) err_q  <= 1'b1;
    end
  end

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q & ~MODE_MASK) == '0);
  // R9
  guarded_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mode_q[BIT_SWR] && (((wr_data & MODE_MASK) ^ mode_q) & ~SWR_ONLY) != '0)
    |=> ($stable(mode_q) && err_q));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/codec_run_seq.sv
module codec_run_seq
  import codec_mode_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic swr,
  input  logic enc,
  input  logic vblank,
  input  logic field_end,
  output logic run_en
);
  seq_state_t state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      SEQ_IDLE:  if (!swr) nxt = SEQ_RUN;
      SEQ_RUN:   if (swr) nxt = (enc && !vblank) ? SEQ_DRAIN : SEQ_IDLE;
      SEQ_DRAIN: if (field_end) nxt = SEQ_IDLE;
                 else if (!swr) nxt = SEQ_RUN;
      default:   nxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SEQ_IDLE;
      run_en <= 1'b0;
    end else begin
      state  <= nxt;
      run_en <= (nxt != SEQ_IDLE);
    end
  end

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_IDLE && swr) |=> !run_en);
  // R4
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_IDLE && !swr) |=> run_en);
  // R5 and R7
  quick_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_RUN && swr && (!enc || vblank)) |=> !run_en);
  // R6
  drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_DRAIN && !field_end) |=> run_en);
  // R6
  drain_end_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_DRAIN && field_end) |=> !run_en);
endmodule

// File: rtl/codec_pin_pol.sv
module codec_pin_pol #(
  parameter int              NPIN    = 2,
  parameter logic [NPIN-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] raw,
  input  logic [NPIN-1:0] inv,
  output logic [NPIN-1:0] pin_q
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) pin_q[i] <= RST_VAL[i];
      else     pin_q[i] <= raw[i] ^ inv[i];
    end
  end
endmodule

// File: rtl/codec_mode_ctrl.sv
module codec_mode_ctrl
  import codec_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  input  logic              field_end,
  input  logic              vblank,
  input  logic              hblank,
  input  logic              irq_req,
  output logic [MODE_W-1:0] rd_data,
  output logic              enc_mode,
  output logic              unipolar,
  output logic              qbox_en,
  output logic              stall_en,
  output logic              run_en,
  output logic              proto_err,
  output logic              hsync_o,
  output logic              irq_o
);
  localparam int NPIN = 2;
  localparam logic [NPIN-1:0] PIN_RST = 2'b10;

  logic [MODE_W-1:0] mode_q;
  logic [NPIN-1:0]   pin_raw, pin_inv, pin_q;

  codec_mode_reg u_reg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .mode_q (mode_q),
    .err_q  (proto_err)
  );

  codec_run_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .swr      (mode_q[BIT_SWR]),
    .enc      (mode_q[BIT_DIR]),
    .vblank   (vblank),
    .field_end(field_end),
    .run_en   (run_en)
  );

  always_comb begin
    pin_raw = {irq_req, hblank};
    pin_inv = {~mode_q[BIT_IPOL], mode_q[BIT_HPOL]};
  end

  codec_pin_pol #(.NPIN(NPIN), .RST_VAL(PIN_RST)) u_pins (
    .clk  (clk),
    .rst  (rst),
    .raw  (pin_raw),
    .inv  (pin_inv),
    .pin_q(pin_q)
  );

  assign hsync_o  = pin_q[0];
  assign irq_o    = pin_q[1];
  assign rd_data  = mode_q;
  assign enc_mode = mode_q[BIT_DIR];
  assign unipolar = mode_q[BIT_UNI];
  assign qbox_en  = mode_q[BIT_QBOX];
  assign stall_en = mode_q[BIT_STALL];

  // R10
  hsync_pol_chk: assert property (@(posedge clk) disable iff (rst)
    (hblank && !mode_q[BIT_HPOL]) |=> hsync_o);
  // R11
  irq_pol_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !mode_q[BIT_IPOL]) |=> !irq_o);
endmodule

// File: tb/codec_mode_ctrl_tb.sv
module codec_mode_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        field_end = 1'b0, vblank = 1'b0, hblank = 1'b0, irq_req = 1'b0;
  logic [15:0] rd_data;
  logic        enc_mode, unipolar, qbox_en, stall_en, run_en, proto_err, hsync_o, irq_o;

  always #4 clk = ~clk;

  codec_mode_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .field_end(field_end), .vblank(vblank), .hblank(hblank), .irq_req(irq_req),
    .rd_data(rd_data), .enc_mode(enc_mode), .unipolar(unipolar), .qbox_en(qbox_en),
    .stall_en(stall_en), .run_en(run_en), .proto_err(proto_err),
    .hsync_o(hsync_o), .irq_o(irq_o)
  );

  // reference model: 0 idle, 1 running, 2 draining
  logic [15:0] m_mode;
  logic        m_err, m_hs, m_iq;
  int          m_st;
  bit          started = 0;
  int          errors = 0, checks = 0;
  string       phase = "R1";

  always @(posedge clk) begin
    logic [15:0] w, nm;
    logic        ne;
    int          ns;
    started <= 1;
    if (rst) begin
      m_mode <= 16'h0880; m_err <= 0; m_st <= 0; m_hs <= 0; m_iq <= 1;
    end else begin
      nm = m_mode; ne = m_err; ns = m_st;
      if (wr_en) begin
        w = wr_data & 16'hFA80;
        if (!m_mode[11] && (((w ^ m_mode) & 16'hF7FF) != 0)) ne = 1;
        else nm = w;
      end
      case (m_st)
        0: if (!m_mode[11]) ns = 1;
        1: if (m_mode[11]) ns = (m_mode[7] && !vblank) ? 2 : 0;
        default: if (field_end) ns = 0; else if (!m_mode[11]) ns = 1;
      endcase
      m_hs   <= m_mode[12] ? ~hblank : hblank;
      m_iq   <= m_mode[13] ? irq_req : ~irq_req;
      m_mode <= nm; m_err <= ne; m_st <= ns;
    end
  end

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("rd_data", rd_data, m_mode);
    chk("enc_mode", 16'(enc_mode), 16'(m_mode[7]));
    chk("unipolar", 16'(unipolar), 16'(m_mode[9]));
    chk("qbox_en", 16'(qbox_en), 16'(m_mode[14]));
    chk("stall_en", 16'(stall_en), 16'(m_mode[15]));
    chk("run_en", 16'(run_en), 16'(m_st != 0));
    chk("proto_err", 16'(proto_err), 16'(m_err));
    chk("hsync_o", 16'(hsync_o), 16'(m_hs));
    chk("irq_o", 16'(irq_o), 16'(m_iq));
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    phase = "R1";  idle(3); @(negedge clk); rst = 0; idle(3);
    phase = "R4";  idle(4); wr(16'h0080); idle(4);
    phase = "R9";  wr(16'h0280); idle(2); wr(16'h0082); idle(2);
    phase = "R6";  vblank = 0; wr(16'h0880); idle(6);
    @(negedge clk); field_end = 1; @(negedge clk); field_end = 0; idle(3);
    phase = "R3";  wr(16'hFFFF); idle(2); wr(16'h057F | 16'h0800); idle(2);
    phase = "R2";  wr(16'hFA00); idle(2); wr(16'hF200); idle(4);
    phase = "R10"; for (int i = 0; i < 6; i++) begin @(negedge clk); hblank = i[0]; end
    phase = "R11"; for (int i = 0; i < 6; i++) begin @(negedge clk); irq_req = i[1]; end
    phase = "R5";  wr(16'hFA00); idle(4); wr(16'h0000); wr(16'h0800); idle(3);
    phase = "R10"; wr(16'h0880); for (int i = 0; i < 6; i++) begin @(negedge clk); hblank = i[0]; irq_req = i[0]; end
    phase = "R7";  wr(16'h0080); idle(3); vblank = 1; wr(16'h0880); idle(4); vblank = 0;
    phase = "R8";  wr(16'h0080); idle(3); wr(16'h0880); idle(3); wr(16'h0080); idle(4);
    @(negedge clk); field_end = 1; @(negedge clk); field_end = 0; idle(2);
    phase = "R2";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      field_end = ($urandom_range(0, 7) == 0);
      vblank    = ($urandom_range(0, 3) == 0);
      hblank    = 1'($urandom);
      irq_req   = 1'($urandom);
      wr_en     = ($urandom_range(0, 5) == 0);
      wr_data   = 16'($urandom);
    end
    @(negedge clk); wr_en = 0; field_end = 0;
    phase = "R1"; rst = 1; idle(2); rst = 0; idle(2);
    summary();
  end
endmodule